// File: doc/BRIEF.md
# Double-Buffered Polyphase Coefficient Store

This block holds the filter coefficients that a polyphase image scaler applies to each output pixel. Control software loads coefficients through two register-style write ports. A select write sets the filter type, the phase, the starting tap pair and the number of tap pairs per phase. Each following data write stores one even-tap and one odd-tap coefficient, and each of the two has its own enable. Only the first half of the phase range is stored, as phases 0 to 32 of a 64-phase filter, with up to four tap pairs per phase. After every data write the pointer moves on by itself, so a single select write followed by a burst of data writes fills one filter type.

Two complete banks exist. Data writes always land in the bank that is not current. Software loads the idle bank and then writes the opposite bank value to a swap port. The bank control state machine has two states. In BK_STEADY no swap is waiting. It moves to BK_ARMED when a swap write names the non-current bank. From BK_ARMED it returns to BK_STEADY in one of two ways: a frame-start strobe flips the current bank, or a swap write that names the current bank cancels the request. The filter datapath therefore never reads a half-loaded bank. The datapath reads through a one-cycle-latency port that looks up the bank current in the cycle of the request. When chroma coefficient mode is off, the chroma filter types read the matching luma coefficients.

Top module: `coef_store`

## Requirements
- R1: After reset `cur_bank` is 0 and `rd_valid` is 0.
- R2: A data write stores its coefficients at the pointer (type, phase, pair) in the non-current bank, with bits [1:0] of each stored coefficient forced to zero. Type codes: 0 luma vertical, 1 luma horizontal, 2 chroma vertical, 3 chroma horizontal, 4 alpha vertical, 5 alpha horizontal.
- R3: `dat_even_en` and `dat_odd_en` act independently. A half whose enable is low keeps its previous value.
- R4: After each data write the pair index increments. When the index equals `sel_last` (the pair count minus one) it wraps to 0 and the phase increments, and phase 32 wraps to phase 0.
- R5: A swap write whose value differs from `cur_bank` arms a swap, and `cur_bank` flips on the edge where the next `frame_start` is high. A `frame_start` with nothing armed has no effect. A swap write equal to `cur_bank` while armed cancels the request.
- R6: `rd_valid` follows `rd_en` one cycle later, and the data comes from the bank that was current in the request cycle, including a request made in the same cycle as a swapping `frame_start`.
- R7: Loading never changes what reads of the current bank return.
- R8: With `chroma_own` low, reads of types 2 and 3 return types 0 and 1. With it high, they return their own entries. Alpha types are never remapped.
- R9: A data write whose pointer has type 6 or higher, or phase 33 or higher, stores nothing, but the pointer still advances. A read of such an address returns zero with `rd_valid` high.
- R10: When `sel_wr` and `dat_wr` are high in the same cycle, the select write takes effect and the data write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Select register write strobe |
| sel_type | input | 3 | Filter type to load |
| sel_phase | input | 6 | Starting phase |
| sel_pair | input | 2 | Starting tap pair |
| sel_last | input | 2 | Tap pairs per phase minus one |
| dat_wr | input | 1 | Data register write strobe |
| dat_even | input | 14 | Even tap coefficient |
| dat_even_en | input | 1 | Store the even coefficient |
| dat_odd | input | 14 | Odd tap coefficient |
| dat_odd_en | input | 1 | Store the odd coefficient |
| swap_wr | input | 1 | Bank select write strobe |
| swap_val | input | 1 | Requested current bank |
| frame_start | input | 1 | Frame boundary strobe |
| chroma_own | input | 1 | Chroma types use their own coefficients |
| rd_en | input | 1 | Read request |
| rd_type | input | 3 | Read filter type |
| rd_phase | input | 6 | Read phase |
| rd_pair | input | 2 | Read tap pair |
| rd_valid | output | 1 | Read data valid |
| rd_even | output | 14 | Even coefficient read |
| rd_odd | output | 14 | Odd coefficient read |
| cur_bank | output | 1 | Bank currently used by reads |

## Verification
The hardest case to reach is a read issued in the same cycle as the frame strobe that completes an armed swap. The answer must come from the outgoing bank even though `cur_bank` changes on that edge. The bench loads different values for one address into each bank, arms the swap, and then drives `rd_en` and `frame_start` together. It also reaches the phase-32 wrap by placing the pointer at phase 31 with two pairs per phase. Finally, it places a data write on an out-of-range phase whose linear position would alias a real entry, and confirms through a later read that the entry is unchanged.

// File: rtl/coef_store_pkg.sv
package coef_store_pkg;

    // Bank control states
    typedef enum logic [0:0] {
        BK_STEADY = 1'b0,
        BK_ARMED  = 1'b1
    } bank_state_e;

    // Filter type codes that the read remapping depends on
    localparam int FT_CHROMA_V    = 2;
    localparam int FT_CHROMA_H    = 3;
    localparam int CHROMA_TO_LUMA = 2;

endpackage

// File: rtl/coef_wr_ptr.sv
module coef_wr_ptr #(
    parameter int TYPE_W   = 3,
    parameter int PHASE_W  = 6,
    parameter int PAIR_W   = 2,
    parameter int N_PHASES = 33,
    parameter int N_PAIRS  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic [TYPE_W-1:0]  sel_type,
    input  logic [PHASE_W-1:0] sel_phase,
    input  logic [PAIR_W-1:0]  sel_pair,
    input  logic [PAIR_W-1:0]  sel_last,
    input  logic               dat_wr,
    output logic [TYPE_W-1:0]  ptr_type,
    output logic [PHASE_W-1:0] ptr_phase,
    output logic [PAIR_W-1:0]  ptr_pair,
    output logic               adv
);
    localparam logic [PHASE_W-1:0] LAST_PH  = PHASE_W'(N_PHASES - 1);
    localparam logic [PAIR_W-1:0]  DEF_LAST = PAIR_W'(N_PAIRS - 1);

    logic [PAIR_W-1:0] last_q;

    // A data write advances the pointer only when no select write competes
    assign adv = dat_wr && !sel_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_type  <= '0;
            ptr_phase <= '0;
            ptr_pair  <= '0;
            last_q    <= DEF_LAST;
        end else if (sel_wr) begin
            ptr_type  <= sel_type;
            ptr_phase <= sel_phase;
            ptr_pair  <= sel_pair;
            last_q    <= sel_last;
        end else if (dat_wr) begin
            if (ptr_pair == last_q) begin
                ptr_pair  <= '0;
                ptr_phase <= (ptr_phase == LAST_PH) ? '0 : ptr_phase + 1'b1;
            end else begin
                ptr_pair  <= ptr_pair + 1'b1;
            end
        end
    end

    // R4
    pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr_pair != last_q) |=> (ptr_pair == PAIR_W'($past(ptr_pair) + 1'b1)));

    // R4
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ptr_pair == last_q && ptr_phase == LAST_PH) |=> (ptr_phase == '0 && ptr_pair == '0));

    // R10
    sel_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && dat_wr) |=> (ptr_phase == $past(sel_phase) && ptr_pair == $past(sel_pair)));

endmodule

// File: rtl/coef_bank_ctrl.sv
module coef_bank_ctrl
    import coef_store_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic swap_wr,
    input  logic swap_val,
    input  logic frame_start,
    output logic cur_bank
);
    bank_state_e state_q, state_d;
    logic        cur_q, cur_d;
    logic        arm, cancel;

    assign arm    = swap_wr && (swap_val != cur_q);
    assign cancel = swap_wr && (swap_val == cur_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BK_STEADY;
            cur_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_STEADY: if (arm)              state_d = BK_ARMED;
            BK_ARMED:  if (cancel)           state_d = BK_STEADY;
                       else if (frame_start) state_d = BK_STEADY;
        endcase
    end

    // Outputs
    always_comb begin
        cur_d = cur_q;
        unique case (state_q)
            BK_STEADY: cur_d = cur_q;
            BK_ARMED:  if (!cancel && frame_start) cur_d = !cur_q;
        endcase
    end

    assign cur_bank = cur_q;

    // R5
    flip_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q) |-> $past(frame_start));

    // R5
    armed_frame_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_ARMED && frame_start && !cancel) |=> (cur_q != $past(cur_q)));

    // R5
    steady_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BK_STEADY) |=> $stable(cur_q));

endmodule

// File: rtl/coef_bank_mem.sv
module coef_bank_mem #(
    parameter int COEF_W = 14,
    parameter int DEPTH  = 792,
    parameter int AW     = 10
) (
    input  logic              clk,
    input  logic              we_even,
    input  logic              we_odd,
    input  logic [AW-1:0]     waddr,
    input  logic [COEF_W-1:0] wd_even,
    input  logic [COEF_W-1:0] wd_odd,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [COEF_W-1:0] rd_even,
    output logic [COEF_W-1:0] rd_odd
);
    logic [COEF_W-1:0] mem_e [DEPTH];
    logic [COEF_W-1:0] mem_o [DEPTH];

    always_ff @(posedge clk) begin
        if (we_even) mem_e[waddr] <= wd_even;
        if (we_odd)  mem_o[waddr] <= wd_odd;
        if (re) begin
            rd_even <= mem_e[raddr];
            rd_odd  <= mem_o[raddr];
        end
    end

endmodule

// File: rtl/coef_store.sv
module coef_store
    import coef_store_pkg::*;
#(
    parameter int COEF_W      = 14,
    parameter int N_TYPES     = 6,
    parameter int FULL_PHASES = 64,
    parameter int MAX_TAPS    = 8,
    parameter int LSB_ZERO    = 2,
    localparam int N_PHASES   = FULL_PHASES / 2 + 1,
    localparam int N_PAIRS    = (MAX_TAPS + 1) / 2,
    localparam int TYPE_W     = $clog2(N_TYPES),
    localparam int PHASE_W    = $clog2(FULL_PHASES),
    localparam int PAIR_W     = $clog2(N_PAIRS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_wr,
    input  logic [TYPE_W-1:0]  sel_type,
    input  logic [PHASE_W-1:0] sel_phase,
    input  logic [PAIR_W-1:0]  sel_pair,
    input  logic [PAIR_W-1:0]  sel_last,
    input  logic               dat_wr,
    input  logic [COEF_W-1:0]  dat_even,
    input  logic               dat_even_en,
    input  logic [COEF_W-1:0]  dat_odd,
    input  logic               dat_odd_en,
    input  logic               swap_wr,
    input  logic               swap_val,
    input  logic               frame_start,
    input  logic               chroma_own,
    input  logic               rd_en,
    input  logic [TYPE_W-1:0]  rd_type,
    input  logic [PHASE_W-1:0] rd_phase,
    input  logic [PAIR_W-1:0]  rd_pair,
    output logic               rd_valid,
    output logic [COEF_W-1:0]  rd_even,
    output logic [COEF_W-1:0]  rd_odd,
    output logic               cur_bank
);
    localparam int DEPTH  = N_TYPES * N_PHASES * N_PAIRS;
    localparam int AW     = $clog2(DEPTH);
    localparam int N_BANK = 2;
    localparam logic [COEF_W-1:0] KEEP_MASK = ~COEF_W'((1 << LSB_ZERO) - 1);

    function automatic logic [AW-1:0] lin_addr(input logic [TYPE_W-1:0]  t,
                                               input logic [PHASE_W-1:0] p,
                                               input logic [PAIR_W-1:0]  q);
        lin_addr = AW'((int'(t) * N_PHASES + int'(p)) * N_PAIRS + int'(q));
    endfunction

    // Write pointer
    logic [TYPE_W-1:0]  ptr_type;
    logic [PHASE_W-1:0] ptr_phase;
    logic [PAIR_W-1:0]  ptr_pair;
    logic               adv;

    coef_wr_ptr #(
        .TYPE_W(TYPE_W), .PHASE_W(PHASE_W), .PAIR_W(PAIR_W),
        .N_PHASES(N_PHASES), .N_PAIRS(N_PAIRS)
    ) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .sel_wr(sel_wr), .sel_type(sel_type), .sel_phase(sel_phase),
        .sel_pair(sel_pair), .sel_last(sel_last), .dat_wr(dat_wr),
        .ptr_type(ptr_type), .ptr_phase(ptr_phase), .ptr_pair(ptr_pair),
        .adv(adv)
    );

    // Bank control
    coef_bank_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .swap_wr(swap_wr), .swap_val(swap_val),
        .frame_start(frame_start), .cur_bank(cur_bank)
    );

    // Write side
    logic              wr_ok, wr_go;
    logic [AW-1:0]     waddr;
    logic [COEF_W-1:0] wd_e, wd_o;

    assign wr_ok = (ptr_type < TYPE_W'(N_TYPES)) && (ptr_phase < PHASE_W'(N_PHASES));
    assign wr_go = adv && wr_ok;
    assign waddr = lin_addr(ptr_type, ptr_phase, ptr_pair);
    assign wd_e  = dat_even & KEEP_MASK;
    assign wd_o  = dat_odd  & KEEP_MASK;

    // Read side with chroma remapping
    logic              rd_ok, is_chroma;
    logic [TYPE_W-1:0] map_type;
    logic [AW-1:0]     raddr;

    assign is_chroma = (rd_type == TYPE_W'(FT_CHROMA_V)) || (rd_type == TYPE_W'(FT_CHROMA_H));
    assign map_type  = (!chroma_own && is_chroma) ? rd_type - TYPE_W'(CHROMA_TO_LUMA) : rd_type;
    assign rd_ok     = (rd_type < TYPE_W'(N_TYPES)) && (rd_phase < PHASE_W'(N_PHASES));
    assign raddr     = lin_addr(map_type, rd_phase, rd_pair);

    logic [COEF_W-1:0] bank_e [N_BANK];
    logic [COEF_W-1:0] bank_o [N_BANK];

    for (genvar b = 0; b < N_BANK; b++) begin : g_bank
        logic idle_bank;
        assign idle_bank = (cur_bank != 1'(b));
        coef_bank_mem #(.COEF_W(COEF_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
            .clk(clk),
            .we_even(wr_go && dat_even_en && idle_bank),
            .we_odd(wr_go && dat_odd_en && idle_bank),
            .waddr(waddr), .wd_even(wd_e), .wd_odd(wd_o),
            .re(rd_en && rd_ok && !idle_bank),
            .raddr(raddr),
            .rd_even(bank_e[b]), .rd_odd(bank_o[b])
        );
    end

    logic rd_valid_q, rd_ok_q, rd_bank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_ok_q    <= 1'b0;
            rd_bank_q  <= 1'b0;
        end else begin
            rd_valid_q <= rd_en;
            if (rd_en) begin
                rd_ok_q   <= rd_ok;
                rd_bank_q <= cur_bank;
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_even  = (rd_valid_q && rd_ok_q) ? bank_e[rd_bank_q] : '0;
    assign rd_odd   = (rd_valid_q && rd_ok_q) ? bank_o[rd_bank_q] : '0;

    // R6
    rd_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R6
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R2
    lsb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_even[LSB_ZERO-1:0] == '0 && rd_odd[LSB_ZERO-1:0] == '0));

    // R9
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_ok) |=> (rd_even == '0 && rd_odd == '0));

endmodule

// File: tb/tb_coef_store.sv
`timescale 1ns/1ps
module tb_coef_store;
    logic clk = 0;
    logic rst_n = 0;
    logic sel_wr = 0, dat_wr = 0, dat_even_en = 0, dat_odd_en = 0;
    logic swap_wr = 0, swap_val = 0, frame_start = 0, chroma_own = 1, rd_en = 0;
    logic [2:0]  sel_type = 0, rd_type = 0;
    logic [5:0]  sel_phase = 0, rd_phase = 0;
    logic [1:0]  sel_pair = 0, sel_last = 0, rd_pair = 0;
    logic [13:0] dat_even = 0, dat_odd = 0;
    logic        rd_valid, cur_bank;
    logic [13:0] rd_even, rd_odd;

    always #10 clk = ~clk;

    coef_store dut (
        .clk(clk), .rst_n(rst_n),
        .sel_wr(sel_wr), .sel_type(sel_type), .sel_phase(sel_phase),
        .sel_pair(sel_pair), .sel_last(sel_last),
        .dat_wr(dat_wr), .dat_even(dat_even), .dat_even_en(dat_even_en),
        .dat_odd(dat_odd), .dat_odd_en(dat_odd_en),
        .swap_wr(swap_wr), .swap_val(swap_val), .frame_start(frame_start),
        .chroma_own(chroma_own),
        .rd_en(rd_en), .rd_type(rd_type), .rd_phase(rd_phase), .rd_pair(rd_pair),
        .rd_valid(rd_valid), .rd_even(rd_even), .rd_odd(rd_odd), .cur_bank(cur_bank)
    );

    // Reference model
    bit [13:0] me [2][6][33][4];
    bit [13:0] mo [2][6][33][4];
    int mcur = 0, mpend = 0;
    int mt = 0, mph = 0, mpr = 0, mlast = 3;

    int n_chk = 0, n_fail = 0;
    logic [27:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6 unexpected rd_valid", 1, 0);
            end else begin
                logic [27:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk({rd_even, rd_odd} === e, t, int'({rd_even, rd_odd}), int'(e));
            end
        end
    end

    function automatic void mdl_advance();
        if (mpr == mlast) begin
            mpr = 0;
            mph = (mph == 32) ? 0 : (mph + 1) % 64;
        end else begin
            mpr = (mpr + 1) % 4;
        end
    endfunction

    task automatic t_sel(input int t, input int ph, input int pr, input int last);
        @(negedge clk);
        sel_type = 3'(t); sel_phase = 6'(ph); sel_pair = 2'(pr); sel_last = 2'(last);
        sel_wr = 1;
        mt = t; mph = ph; mpr = pr; mlast = last;
        @(negedge clk);
        sel_wr = 0;
    endtask

    task automatic t_dat(input int e, input bit ee, input int o, input bit oe);
        @(negedge clk);
        dat_even = 14'(e); dat_odd = 14'(o); dat_even_en = ee; dat_odd_en = oe;
        dat_wr = 1;
        if (mt < 6 && mph < 33) begin
            if (ee) me[1-mcur][mt][mph][mpr] = 14'(e) & 14'h3FFC;
            if (oe) mo[1-mcur][mt][mph][mpr] = 14'(o) & 14'h3FFC;
        end
        mdl_advance();
        @(negedge clk);
        dat_wr = 0;
    endtask

    // R10 stimulus: select and data writes in one cycle
    task automatic t_sel_dat(input int t, input int ph, input int pr, input int last, input int v);
        @(negedge clk);
        sel_type = 3'(t); sel_phase = 6'(ph); sel_pair = 2'(pr); sel_last = 2'(last);
        dat_even = 14'(v); dat_odd = 14'(v); dat_even_en = 1; dat_odd_en = 1;
        sel_wr = 1; dat_wr = 1;
        mt = t; mph = ph; mpr = pr; mlast = last;
        @(negedge clk);
        sel_wr = 0; dat_wr = 0;
    endtask

    task automatic t_swap(input int v);
        @(negedge clk);
        swap_val = 1'(v); swap_wr = 1;
        if (mpend == 0 && v != mcur) mpend = 1;
        else if (mpend == 1 && v == mcur) mpend = 0;
        @(negedge clk);
        swap_wr = 0;
    endtask

    task automatic mdl_frame();
        if (mpend == 1) begin
            mcur = 1 - mcur;
            mpend = 0;
        end
    endtask

    task automatic t_frame();
        @(negedge clk);
        frame_start = 1;
        mdl_frame();
        @(negedge clk);
        frame_start = 0;
    endtask

    function automatic logic [27:0] mdl_read(input int t, input int ph, input int pr);
        int et;
        if (t >= 6 || ph >= 33) return 28'h0;
        et = (!chroma_own && (t == 2 || t == 3)) ? t - 2 : t;
        return {me[mcur][et][ph][pr], mo[mcur][et][ph][pr]};
    endfunction

    task automatic t_rd(input int t, input int ph, input int pr, input string tag, input bit with_frame);
        @(negedge clk);
        rd_type = 3'(t); rd_phase = 6'(ph); rd_pair = 2'(pr);
        rd_en = 1;
        exp_q.push_back(mdl_read(t, ph, pr));
        tag_q.push_back(tag);
        if (with_frame) begin
            frame_start = 1;
            mdl_frame();
        end
        @(negedge clk);
        rd_en = 0;
        frame_start = 0;
    endtask

    task automatic chk_bank(input string tag);
        @(negedge clk);
        chk(cur_bank == 1'(mcur), tag, int'(cur_bank), mcur);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(cur_bank == 1'b0, "R1 cur_bank after reset", int'(cur_bank), 0);
        chk(rd_valid == 1'b0, "R1 rd_valid after reset", int'(rd_valid), 0);

        // R2: luma horizontal, phases 0-1, four pairs, low bits set
        t_sel(1, 0, 0, 3);
        for (int i = 0; i < 8; i++) t_dat(i * 300 + 7, 1, i * 300 + 151, 1);

        // R4: two pairs per phase, crossing phase 32 into phase 0
        t_sel(0, 31, 0, 1);
        for (int i = 0; i < 6; i++) t_dat(5000 + i * 13 + 1, 1, 9000 + i * 17 + 2, 1);

        // R8 data: phase 5 pair 0 of types 0..3
        for (int t = 0; t < 4; t++) begin
            t_sel(t, 5, 0, 0);
            t_dat(1000 + t * 111 + 3, 1, 2000 + t * 77, 1);
        end
        t_sel(5, 20, 2, 3);
        t_dat(14'h2D2D, 1, 14'h1B1B, 1);

        // R3: independent enables on type 1 phase 1 pairs 2,3
        t_sel(1, 1, 2, 3);
        t_dat(14'h3ABC, 1, 14'h1111, 0);
        t_dat(14'h2222, 0, 14'h0F0F, 1);

        // R9: preload the entry that phase 40 of type 1 would alias
        t_sel(2, 7, 0, 3);
        t_dat(14'h1357, 1, 14'h2468, 1);
        t_sel(1, 40, 0, 3);
        t_dat(14'h3FFF, 1, 14'h3FFF, 1);
        t_sel(6, 0, 0, 3);
        t_dat(14'h3FFF, 1, 14'h3FFF, 1);

        // R10: select wins over a same-cycle data write
        t_sel(4, 3, 0, 3);
        t_dat(14'h0444, 1, 14'h0555, 1);
        t_dat(14'h0666, 1, 14'h0777, 1);
        t_sel(4, 3, 1, 3);
        t_sel_dat(4, 10, 0, 3, 14'h3333);
        t_dat(14'h0888, 1, 14'h0999, 1);

        // R5: armed swap waits for the frame strobe
        t_swap(1);
        chk_bank("R5 armed swap holds before frame_start");
        t_frame();
        chk_bank("R5 swap on frame_start");
        t_frame();
        chk_bank("R5 frame_start without armed swap");

        // Reads of the loaded bank
        chroma_own = 1;
        for (int ph = 0; ph < 2; ph++)
            for (int pr = 0; pr < 4; pr++)
                t_rd(1, ph, pr, "R2 luma horizontal entry", 0);
        t_rd(0, 31, 0, "R4 phase 31 pair 0", 0);
        t_rd(0, 31, 1, "R4 phase 31 pair 1", 0);
        t_rd(0, 32, 0, "R4 phase 32 pair 0", 0);
        t_rd(0, 32, 1, "R4 phase 32 pair 1", 0);
        t_rd(0, 0, 0, "R4 wrap to phase 0 pair 0", 0);
        t_rd(0, 0, 1, "R4 wrap to phase 0 pair 1", 0);
        t_rd(1, 1, 2, "R3 odd kept, even written", 0);
        t_rd(1, 1, 3, "R3 even kept, odd written", 0);
        t_rd(2, 7, 0, "R9 aliased entry untouched", 0);
        t_rd(6, 0, 0, "R9 type out of range reads zero", 0);
        t_rd(1, 40, 0, "R9 phase out of range reads zero", 0);
        t_rd(4, 3, 0, "R10 first word", 0);
        t_rd(4, 3, 1, "R10 dropped data left entry alone", 0);
        t_rd(4, 10, 0, "R10 pointer from select", 0);
        t_rd(2, 5, 0, "R8 chroma own vertical", 0);
        t_rd(3, 5, 0, "R8 chroma own horizontal", 0);
        @(negedge clk);
        chroma_own = 0;
        t_rd(2, 5, 0, "R8 chroma vertical maps to luma", 0);
        t_rd(3, 5, 0, "R8 chroma horizontal maps to luma", 0);
        t_rd(5, 20, 2, "R8 alpha not remapped", 0);
        @(negedge clk);
        chroma_own = 1;

        // R7: loading the idle bank leaves the current bank alone
        t_sel(1, 0, 0, 3);
        t_dat(14'h0AAA, 1, 14'h0BBB, 1);
        t_rd(1, 0, 0, "R7 current bank unchanged by load", 0);

        // R5 cancel
        t_swap(0);
        t_swap(1);
        t_frame();
        chk_bank("R5 cancelled swap ignored at frame_start");

        // R6: read in the same cycle as the swapping frame strobe
        t_swap(0);
        t_rd(1, 0, 0, "R6 read uses bank current at request", 1);
        chk_bank("R6 swap completed with read");
        t_rd(1, 0, 0, "R6 read after swap sees new bank", 0);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all reads answered", exp_q.size(), 0);
        finish_run();
    end
endmodule